// File: doc/BRIEF.md
# RMII Receive Elasticity Buffer

This block moves received dibits from the recovered receive clock into the local 50 MHz reference clock. Over a long frame the two clocks can drift apart by a few tens of ppm. A small dual-clock FIFO absorbs that drift. The write side captures one dibit per receive-clock cycle while the receive data-valid input is high. The read side holds back output until enough bits are stored, then sends one dibit per reference-clock cycle until the frame has drained.

A 2-bit start field sets how many bits must be stored before a frame is released. A small setting gives low latency but tolerates only short frames. A large setting adds latency and carries much longer frames. The bit counts for the four codes are 4, 8, 12 and 16 bits. The matching slip margins are 2, 6, 10 and 14 bits. At ±50 ppm per clock these cover frames of about 2400, 7200, 12000 and 16800 bytes, and half those lengths at ±100 ppm.

If the FIFO fills up or runs dry inside a frame, the block damages the rest of that frame on purpose so the MAC sees a checksum error. It also raises a sticky status flag, which clears when software reads the status. The FIFO pointers cross between the clock domains as Gray codes through two-flop synchronizers.

Top module: `rmii_rx_elastic`

## Requirements
- R1: The start code selects the number of buffered dibits needed before output begins: code 1 = 2 dibits (4 bits), code 2 = 4 dibits, code 3 = 6 dibits, code 0 = 8 dibits. With both clocks at the same rate, the first output dibit appears between thr+1 and thr+3 reference-clock cycles after the first input dibit is captured, where thr is the dibit count.
- R2: A frame with no overrun and no underrun comes out with the same dibits, in the same order and with the same count, and `out_dv` is high without a gap from the first dibit to the last.
- R3: A frame shorter than its start threshold is still delivered in full once `rx_dv_in` falls.
- R4: A dibit that arrives while the FIFO is full (16 entries) is dropped. The overrun flag is then set, and every later dibit of that frame is delivered inverted.
- R5: If the FIFO is empty while the frame is still open, the block emits a pad dibit 2'b00 with `out_dv` high, sets the underrun flag, and inverts every later dibit of that frame.
- R6: Both flags stay set until `status_rd` is high at a reference-clock edge, which clears them from that edge on. An error event at the same edge wins.
- R7: After a synchronous reset, `out_dv`, `out_dibit` and both flags are 0.
- R8: Once a frame has ended and drained, `out_dv` drops, and the next frame again waits for its full start threshold.
- R9: The fill level seen by the read side never exceeds the FIFO depth, and the read side never pops an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_dv_in | input | 1 | Receive data valid, marks the dibits of a frame |
| rx_dibit_in | input | 2 | Received dibit |
| ref_clk | input | 1 | Reference clock (output domain) |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| start_sel | input | 2 | Start threshold code |
| status_rd | input | 1 | Status read strobe, clears both flags |
| out_dv | output | 1 | Output dibit valid |
| out_dibit | output | 2 | Output dibit |
| overrun_flag | output | 1 | Sticky overrun indication |
| underrun_flag | output | 1 | Sticky underrun indication |

## Verification
The bench sends frames at all four start codes with equal clock rates. This separates the threshold mapping through start latency and shows that data passes through unchanged and in order. A frame shorter than its threshold shows whether release on frame end works apart from the fill count. A reference clock faster than the receive clock forces underrun and pad insertion, and a slower one forces overrun and dropped dibits. Each of these must raise only its own flag, and the flag must hold until a status read clears it.

// File: rtl/rmii_eb_pkg.sv
package rmii_eb_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] dibit;
    } dibit_beat_t;

    // Dibits to hold before release, per start code (4-bit steps, 0 = largest)
    function automatic logic [3:0] start_dibits(input logic [1:0] code);
        case (code)
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            2'd3:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/rmii_eb_sync2.sv
module rmii_eb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rmii_eb_wr.sv
module rmii_eb_wr #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_dibit,
    input  logic [PTR_W-1:0]   rgray_s,
    output logic [PTR_W-1:0]   wgray,
    output logic               frame_open,
    output logic               ovr_seen,
    output logic [2*DEPTH-1:0] mem_flat
);
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

    logic [PTR_W-1:0] wbin, wbin_nx, rbin_s;
    logic             full;

    always_comb begin
        rbin_s[PTR_W-1] = rgray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign full    = ((wbin - rbin_s) == FULL_LVL);
    assign wbin_nx = wbin + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin       <= '0;
            wgray      <= '0;
            frame_open <= 1'b0;
            ovr_seen   <= 1'b0;
            mem_flat   <= '0;
        end else begin
            frame_open <= in_valid;
            if (in_valid && !frame_open) begin
                ovr_seen <= 1'b0;
            end
            if (in_valid) begin
                if (!full) begin
                    mem_flat[2*wbin[ADDR_W-1:0] +: 2] <= in_dibit;
                    wbin  <= wbin_nx;
                    wgray <= wbin_nx ^ (wbin_nx >> 1);
                end else begin
                    ovr_seen <= 1'b1;
                end
            end
        end
    end

    assert_full_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && full) |=> ($stable(wgray) && ovr_seen));

    assert_gray_one_step_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/rmii_eb_rd.sv
module rmii_eb_rd
    import rmii_eb_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         start_sel,
    input  logic               status_rd,
    input  logic [PTR_W-1:0]   wgray_s,
    input  logic               open_s,
    input  logic               ovr_s,
    input  logic [2*DEPTH-1:0] mem_flat,
    output logic [PTR_W-1:0]   rgray,
    output dibit_beat_t        beat,
    output logic               ovr_flag,
    output logic               udr_flag
);
    rd_state_t        state;
    logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, fill, need;
    logic             empty, start_ok, bad_q, ovr_s_q, ovr_edge, udr_evt;
    logic [1:0]       cur;

    always_comb begin
        wbin_s[PTR_W-1] = wgray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign fill     = wbin_s - rbin;
    assign empty    = (fill == '0);
    assign need     = PTR_W'(start_dibits(start_sel));
    assign start_ok = (fill >= need) || (!open_s && !empty);
    assign cur      = mem_flat[2*rbin[ADDR_W-1:0] +: 2];
    assign rbin_nx  = rbin + 1'b1;
    assign ovr_edge = ovr_s && !ovr_s_q;
    assign udr_evt  = (state == RD_RUN) && empty && open_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            rbin     <= '0;
            rgray    <= '0;
            beat     <= '0;
            bad_q    <= 1'b0;
            ovr_s_q  <= 1'b0;
            ovr_flag <= 1'b0;
            udr_flag <= 1'b0;
        end else begin
            ovr_s_q <= ovr_s;
            beat    <= '0;
            case (state)
                RD_IDLE: begin
                    if (start_ok) begin
                        state      <= RD_RUN;
                        rbin       <= rbin_nx;
                        rgray      <= rbin_nx ^ (rbin_nx >> 1);
                        beat.valid <= 1'b1;
                        beat.dibit <= cur;
                    end
                end
                default: begin
                    if (!empty) begin
                        rbin       <= rbin_nx;
                        rgray      <= rbin_nx ^ (rbin_nx >> 1);
                        beat.valid <= 1'b1;
                        beat.dibit <= (bad_q || ovr_s) ? ~cur : cur;
                        bad_q      <= bad_q || ovr_s;
                    end else if (open_s) begin
                        beat.valid <= 1'b1;
                        beat.dibit <= 2'b00;
                        bad_q      <= 1'b1;
                    end else begin
                        state <= RD_IDLE;
                        bad_q <= 1'b0;
                    end
                end
            endcase
            if (status_rd) begin
                ovr_flag <= 1'b0;
                udr_flag <= 1'b0;
            end
            if (ovr_edge) ovr_flag <= 1'b1;
            if (udr_evt)  udr_flag <= 1'b1;
        end
    end

    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
        fill <= PTR_W'(DEPTH));

    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
        empty |=> $stable(rgray));

    assert_underrun_pad_R5: assert property (@(posedge clk) disable iff (rst)
        udr_evt |=> (beat.valid && beat.dibit == 2'b00 && udr_flag));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (udr_flag && !status_rd) |=> udr_flag);

    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !status_rd) |=> ovr_flag);

endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic
    import rmii_eb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       rx_dv_in,
    input  logic [1:0] rx_dibit_in,
    input  logic       ref_clk,
    input  logic       ref_rst,
    input  logic [1:0] start_sel,
    input  logic       status_rd,
    output logic       out_dv,
    output logic [1:0] out_dibit,
    output logic       overrun_flag,
    output logic       underrun_flag
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]   wgray, wgray_r, rgray, rgray_w;
    logic               w_open, w_ovr, open_r, ovr_r;
    logic [2*DEPTH-1:0] mem_flat;
    dibit_beat_t        beat;

    rmii_eb_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (wr_clk),
        .rst        (wr_rst),
        .in_valid   (rx_dv_in),
        .in_dibit   (rx_dibit_in),
        .rgray_s    (rgray_w),
        .wgray      (wgray),
        .frame_open (w_open),
        .ovr_seen   (w_ovr),
        .mem_flat   (mem_flat)
    );

    rmii_eb_sync2 #(.W(PTR_W)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray),
        .q   (rgray_w)
    );

    rmii_eb_sync2 #(.W(PTR_W + 2)) u_w2r (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   ({wgray, w_open, w_ovr}),
        .q   ({wgray_r, open_r, ovr_r})
    );

    rmii_eb_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (ref_clk),
        .rst       (ref_rst),
        .start_sel (start_sel),
        .status_rd (status_rd),
        .wgray_s   (wgray_r),
        .open_s    (open_r),
        .ovr_s     (ovr_r),
        .mem_flat  (mem_flat),
        .rgray     (rgray),
        .beat      (beat),
        .ovr_flag  (overrun_flag),
        .udr_flag  (underrun_flag)
    );

    assign out_dv    = beat.valid;
    assign out_dibit = beat.dibit;

    assert_idle_zero_R7: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !out_dv |-> (out_dibit == 2'b00));

endmodule

// File: tb/rmii_rx_elastic_tb_top.sv
`timescale 1ns/100ps
module rmii_rx_elastic_tb_top;

    logic       wr_clk = 1'b0, ref_clk = 1'b0;
    logic       wr_rst, ref_rst;
    logic       rx_dv_in;
    logic [1:0] rx_dibit_in;
    logic [1:0] start_sel;
    logic       status_rd;
    logic       out_dv;
    logic [1:0] out_dibit;
    logic       overrun_flag, underrun_flag;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    real rd_half = 5.0;

    rmii_rx_elastic dut_i (
        .wr_clk        (wr_clk),
        .wr_rst        (wr_rst),
        .rx_dv_in      (rx_dv_in),
        .rx_dibit_in   (rx_dibit_in),
        .ref_clk       (ref_clk),
        .ref_rst       (ref_rst),
        .start_sel     (start_sel),
        .status_rd     (status_rd),
        .out_dv        (out_dv),
        .out_dibit     (out_dibit),
        .overrun_flag  (overrun_flag),
        .underrun_flag (underrun_flag)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #2.5;
        forever #(rd_half) ref_clk = ~ref_clk;
    end

    // row: sel[17:16] len[15:8] period_ns[7:4] exp_ovr[1] exp_udr[0]
    localparam int NROWS = 7;
    localparam logic [17:0] ROWS [NROWS] = '{
        {2'd1, 8'd20,  4'd10, 2'b00, 2'b00},
        {2'd2, 8'd33,  4'd10, 2'b00, 2'b00},
        {2'd3, 8'd64,  4'd10, 2'b00, 2'b00},
        {2'd0, 8'd50,  4'd10, 2'b00, 2'b00},
        {2'd0, 8'd3,   4'd10, 2'b00, 2'b00},
        {2'd1, 8'd60,  4'd8,  2'b00, 2'b01},
        {2'd2, 8'd120, 4'd14, 2'b00, 2'b10}
    };

    logic [1:0] rx_buf [256];
    int  rx_n;
    bit  got_first;
    int  lat, lat_cap;
    bit  counting;

    always @(posedge ref_clk) if (counting) lat++;

    always @(negedge ref_clk) begin
        if (out_dv) begin
            if (!got_first) begin
                got_first = 1;
                lat_cap   = lat;
                counting  = 0;
            end
            if (rx_n < 256) rx_buf[rx_n] = out_dibit;
            rx_n++;
        end
    end

    function automatic logic [1:0] pat(int r, int i);
        return 2'((i * 5) + r + (i >> 3));
    endfunction

    function automatic int thr_of(logic [1:0] code);
        return (code == 2'd0) ? 8 : 2 * int'(code);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(int r, int len);
        rx_n = 0; got_first = 0; lat = 0; counting = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge wr_clk);
            rx_dv_in    = 1'b1;
            rx_dibit_in = pat(r, i);
            if (i == 0) begin
                @(posedge wr_clk);
                lat = 0;
                counting = 1;
            end
        end
        @(negedge wr_clk);
        rx_dv_in    = 1'b0;
        rx_dibit_in = 2'b00;
        repeat (80) @(negedge wr_clk);
    endtask

    task automatic read_status();
        @(negedge ref_clk);
        status_rd = 1'b1;
        @(negedge ref_clk);
        status_rd = 1'b0;
    endtask

    task automatic do_reset();
        wr_rst = 1'b1; ref_rst = 1'b1;
        repeat (4) @(negedge wr_clk);
        wr_rst = 1'b0; ref_rst = 1'b0;
        repeat (2) @(negedge wr_clk);
    endtask

    initial begin
        rx_dv_in = 0; rx_dibit_in = 0; start_sel = 0; status_rd = 0;
        rx_n = 0; got_first = 0; lat = 0; lat_cap = 0; counting = 0;
        do_reset();
        @(negedge ref_clk);
        chk(out_dv == 0, "R7", "out_dv after reset", int'(out_dv), 0);
        chk(overrun_flag == 0 && underrun_flag == 0, "R7", "flags after reset",
            int'({overrun_flag, underrun_flag}), 0);

        for (int r = 0; r < NROWS; r++) begin
            logic [1:0] sel;
            int len, per, thr, mism;
            bit eo, eu;
            sel = ROWS[r][17:16];
            len = int'(ROWS[r][15:8]);
            per = int'(ROWS[r][7:4]);
            eo  = ROWS[r][1];
            eu  = ROWS[r][0];
            thr = thr_of(sel);
            rd_half   = per / 2.0;
            start_sel = sel;
            repeat (4) @(negedge wr_clk);
            send(r, len);
            if (per == 10 && len >= thr) begin
                chk(lat_cap >= thr + 1 && lat_cap <= thr + 3, "R1 R8",
                    "start latency", lat_cap, thr + 2);
            end
            if (!eo && !eu) begin
                mism = 0;
                for (int i = 0; i < len && i < rx_n; i++)
                    if (rx_buf[i] != pat(r, i)) mism++;
                chk(rx_n == len, (len < thr) ? "R3" : "R2", "dibit count", rx_n, len);
                chk(mism == 0, (len < thr) ? "R3" : "R2", "mismatched dibits", mism, 0);
            end
            if (eo) chk(rx_n < len, "R4", "dropped dibits on overrun", rx_n, len - 1);
            if (eu) chk(rx_n > len, "R5", "pad dibits on underrun", rx_n, len + 1);
            chk(overrun_flag == eo, "R4", "overrun flag", int'(overrun_flag), int'(eo));
            chk(underrun_flag == eu, "R5", "underrun flag", int'(underrun_flag), int'(eu));
            if (eo || eu) begin
                repeat (20) @(negedge ref_clk);
                chk((overrun_flag | underrun_flag) == 1'b1, "R6", "flag still held",
                    int'(overrun_flag | underrun_flag), 1);
                read_status();
                chk(overrun_flag == 0 && underrun_flag == 0, "R6", "cleared by read",
                    int'({overrun_flag, underrun_flag}), 0);
            end
            chk(out_dv == 0, "R8", "out_dv low after drain", int'(out_dv), 0);
        end

        // Directed: overrun again, then reset clears the sticky flag
        rd_half = 7.0;
        start_sel = 2'd1;
        send(9, 100);
        chk(overrun_flag == 1, "R4", "overrun flag before reset", int'(overrun_flag), 1);
        rd_half = 5.0;
        do_reset();
        @(negedge ref_clk);
        chk(overrun_flag == 0, "R7", "overrun flag after reset", int'(overrun_flag), 0);
        chk(out_dv == 0 && out_dibit == 0, "R7", "output after reset",
            int'({out_dv, out_dibit}), 0);

        // Directed: a status read with nothing pending leaves data path intact
        read_status();
        start_sel = 2'd3;
        send(11, 40);
        mism = 0;
        for (int i = 0; i < 40 && i < rx_n; i++)
            if (rx_buf[i] != pat(11, i)) mism++;
        chk(rx_n == 40 && mism == 0, "R2", "frame after reset", mism, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int mism;

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule